// File: doc/BRIEF.md
# Bit-Banged Serial Configuration ROM Responder

This block stands in for a small serial configuration memory that host software reaches by writing a control register one bit at a time. Each register write carries a serial clock bit, a serial data-in bit and an access-request bit. The block stores the clock bit from every write and advances its serial state only when a write moves that bit from 0 to 1. On such edges it first collects an 8-bit command, most significant bit first. After the word-read command it collects an 8-bit byte address and then presents 16 bits of the addressed word, one per edge, on a registered data-out bit. After the status-read command it presents 8 zero bits. When a transaction completes, the command, the address and the bit count return to zero, so the next edge starts a new command.

The contents are fixed when the block is built: 64 words of 16 bits. The three lowest words hold a station address. All other words are zero, except the last, which is set so that the 16-bit sum of all words equals a check constant. An access-grant bit follows the request bit of every control write. Any command other than the two reads, and any byte address whose word index lies beyond the last word, sets a sticky error flag that only reset clears.

Top module: `spi_rom_responder`

## Requirements
- R1: After synchronous reset, data-out, grant and the error flag are all 0.
- R2: On every control write the grant output takes the value of that write's request bit in the following cycle, and keeps it until the next write.
- R3: Only a write whose clock bit is 1 while the previous write's clock bit was 0 advances the serial state. Writes that keep the clock at 1 or that take it to 0 leave data-out unchanged and do not shift any bit, whatever their data-in bit is.
- R4: The first 8 edges shift data-in into the command, most significant bit first. Command 0x03 is a word read: the next 8 edges shift in a byte address, most significant bit first, and the word read is byte address shifted right by one (byte addresses 2n and 2n+1 both select word n).
- R5: During a word read, data edge k (k = 0..15) sets data-out to bit 15-k of the selected word, so the word leaves most significant bit first.
- R6: Command 0x05 is a status read: the next 8 edges each set data-out to 0.
- R7: After the 16th data edge of a word read, or the 8th edge of a status read, the next edge is the first command bit of a new transaction.
- R8: Words 0, 1 and 2 hold 0xA4A4, 0xB6B6 and 0xC8C8; words 3 to 62 hold 0; word 63 makes the 16-bit sum of all 64 words equal 0xBABA (so word 63 is 0x9698 with the defaults).
- R9: When the 8th command bit completes a command other than 0x03 or 0x05, the error flag rises in the cycle after that write and not before; it stays set until reset.
- R10: When the 8th address bit completes a byte address whose word index is 64 or more, the error flag rises in the cycle after that write and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control-register write strobe, one cycle per write |
| wr_sclk | input | 1 | Serial clock bit of the written value |
| wr_sdi | input | 1 | Serial data-in bit of the written value |
| wr_req | input | 1 | Access-request bit of the written value |
| sdo | output | 1 | Serial data-out bit, registered |
| gnt | output | 1 | Access-grant bit, registered copy of the last request bit |
| err | output | 1 | Sticky protocol error flag |

## Verification
The hardest situation to reach is an edge that is not an edge: software may rewrite the register many times with the clock bit already high, or lower it, while changing the data bit, and none of this may count. The bench reaches it by inserting such extra writes between every real edge of a full word read, with inverted data bits, and checks that data-out holds and that the word still arrives intact. The two error paths are reached by driving a complete illegal command and a complete out-of-range address, checking the flag is still low one bit before the end, and then resetting the block to continue.

// File: rtl/srr_pkg.sv
package srr_pkg;

  // Serial phase of the responder
  typedef enum logic [2:0] {
    PH_CMD  = 3'd0,
    PH_ADDR = 3'd1,
    PH_DATA = 3'd2,
    PH_STAT = 3'd3,
    PH_BAD  = 3'd4
  } phase_t;

  localparam logic [7:0] CMD_WORD_READ = 8'h03;
  localparam logic [7:0] CMD_STAT_READ = 8'h05;

endpackage

// File: rtl/srr_hostif.sv
module srr_hostif (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_sclk,
  input  logic wr_req,
  output logic step,
  output logic gnt
);

  logic sclk_q;

  // Clock bit seen in the previous control write
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      gnt    <= 1'b0;
    end else if (wr_en) begin
      sclk_q <= wr_sclk;
      gnt    <= wr_req;
    end
  end

  assign step = wr_en & wr_sclk & ~sclk_q;

endmodule

// File: rtl/srr_store.sv
module srr_store #(
  parameter int                WORDS = 64,
  parameter int                DW    = 16,
  parameter int                IDXW  = 7,
  parameter logic [DW-1:0]     STA0  = 16'hA4A4,
  parameter logic [DW-1:0]     STA1  = 16'hB6B6,
  parameter logic [DW-1:0]     STA2  = 16'hC8C8,
  parameter logic [DW-1:0]     CSUM  = 16'hBABA
) (
  input  logic [IDXW-1:0] idx,
  output logic [DW-1:0]   rd_data
);

  localparam int AW = $clog2(WORDS);
  localparam logic [DW-1:0] FILL = CSUM - STA0 - STA1 - STA2;

  function automatic logic [DW-1:0] word_at(input int i);
    if (i == 0)            return STA0;
    else if (i == 1)       return STA1;
    else if (i == 2)       return STA2;
    else if (i == WORDS-1) return FILL;
    else                   return '0;
  endfunction

  logic [DW-1:0] rom [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_rom
    assign rom[i] = word_at(i);
  end

  assign rd_data = (32'(idx) < WORDS) ? rom[idx[AW-1:0]] : '0;

endmodule

// File: rtl/srr_seq.sv
module srr_seq
  import srr_pkg::*;
#(
  parameter int            CMDW  = 8,
  parameter int            ADW   = 8,
  parameter int            DW    = 16,
  parameter int            STW   = 8,
  parameter int            WORDS = 64,
  parameter logic [CMDW-1:0] RD_CMD = CMD_WORD_READ,
  parameter logic [CMDW-1:0] ST_CMD = CMD_STAT_READ,
  localparam int           MAXB  = (DW > CMDW) ? DW : CMDW,
  localparam int           CW    = $clog2(MAXB + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic           sdi,
  input  logic [DW-1:0]  word_data,
  output logic [ADW-2:0] word_idx,
  output logic           sdo,
  output logic           err
);

  phase_t          phase;
  logic [CW-1:0]   cnt;
  logic [CMDW-1:0] cmd;
  logic [ADW-1:0]  addr;

  logic [CMDW-1:0] cmd_nx;
  logic [ADW-1:0]  addr_nx;
  logic [DW-1:0]   shifted;

  assign cmd_nx   = {cmd[CMDW-2:0], sdi};
  assign addr_nx  = {addr[ADW-2:0], sdi};
  assign shifted  = word_data << cnt;
  assign word_idx = addr[ADW-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_CMD;
      cnt   <= '0;
      cmd   <= '0;
      addr  <= '0;
      sdo   <= 1'b0;
      err   <= 1'b0;
    end else if (step) begin
      case (phase)
        PH_CMD: begin
          cmd <= cmd_nx;
          if (cnt == CW'(CMDW-1)) begin
            cnt <= '0;
            if (cmd_nx == RD_CMD)      phase <= PH_ADDR;
            else if (cmd_nx == ST_CMD) phase <= PH_STAT;
            else begin
              phase <= PH_BAD;
              err   <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ADDR: begin
          addr <= addr_nx;
          if (cnt == CW'(ADW-1)) begin
            cnt   <= '0;
            phase <= PH_DATA;
            if (32'(addr_nx[ADW-1:1]) >= WORDS) err <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DATA: begin
          sdo <= shifted[DW-1];
          if (cnt == CW'(DW-1)) begin
            phase <= PH_CMD;
            cnt   <= '0;
            cmd   <= '0;
            addr  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_STAT: begin
          sdo <= 1'b0;
          if (cnt == CW'(STW-1)) begin
            phase <= PH_CMD;
            cnt   <= '0;
            cmd   <= '0;
            addr  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          err <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/spi_rom_responder.sv
module spi_rom_responder
  import srr_pkg::*;
#(
  parameter int              WORDS = 64,
  parameter int              DW    = 16,
  parameter int              CMDW  = 8,
  parameter int              ADW   = 8,
  parameter int              STW   = 8,
  parameter logic [CMDW-1:0] RD_CMD = CMD_WORD_READ,
  parameter logic [CMDW-1:0] ST_CMD = CMD_STAT_READ,
  parameter logic [DW-1:0]   STA0  = 16'hA4A4,
  parameter logic [DW-1:0]   STA1  = 16'hB6B6,
  parameter logic [DW-1:0]   STA2  = 16'hC8C8,
  parameter logic [DW-1:0]   CSUM  = 16'hBABA
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_sclk,
  input  logic wr_sdi,
  input  logic wr_req,
  output logic sdo,
  output logic gnt,
  output logic err
);

  localparam int IDXW = ADW - 1;

  logic            step;
  logic [IDXW-1:0] word_idx;
  logic [DW-1:0]   word_data;

  srr_hostif u_hostif (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sclk (wr_sclk),
    .wr_req  (wr_req),
    .step    (step),
    .gnt     (gnt)
  );

  srr_store #(
    .WORDS (WORDS),
    .DW    (DW),
    .IDXW  (IDXW),
    .STA0  (STA0),
    .STA1  (STA1),
    .STA2  (STA2),
    .CSUM  (CSUM)
  ) u_store (
    .idx     (word_idx),
    .rd_data (word_data)
  );

  srr_seq #(
    .CMDW   (CMDW),
    .ADW    (ADW),
    .DW     (DW),
    .STW    (STW),
    .WORDS  (WORDS),
    .RD_CMD (RD_CMD),
    .ST_CMD (ST_CMD)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .sdi       (wr_sdi),
    .word_data (word_data),
    .word_idx  (word_idx),
    .sdo       (sdo),
    .err       (err)
  );

endmodule

// File: rtl/srr_chk.sv
module srr_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic wr_sclk,
  input logic wr_req,
  input logic sdo,
  input logic gnt,
  input logic err
);

  // Checker's own record of the last written clock bit
  logic sclk_seen;
  always_ff @(posedge clk) begin
    if (rst)        sclk_seen <= 1'b0;
    else if (wr_en) sclk_seen <= wr_sclk;
  end

  // R2
  grant_follow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (gnt == $past(wr_req)));

  // R2
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(gnt));

  // R3
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_sclk && !sclk_seen) |=> $stable(sdo));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(wr_en && wr_sclk && !sclk_seen));

endmodule

bind spi_rom_responder srr_chk u_srr_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_sclk (wr_sclk),
  .wr_req  (wr_req),
  .sdo     (sdo),
  .gnt     (gnt),
  .err     (err)
);

// File: tb/tb_spi_rom_responder.sv
`timescale 1ns/1ps
module tb_spi_rom_responder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_sclk = 1'b0, wr_sdi = 1'b0, wr_req = 1'b0;
  logic sdo, gnt, err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spi_rom_responder dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sclk(wr_sclk),
    .wr_sdi(wr_sdi), .wr_req(wr_req), .sdo(sdo), .gnt(gnt), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; wr_sclk = 1'b0; wr_sdi = 1'b0; wr_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // One control write, starting and ending at a falling clock edge
  task automatic wr(input logic s, input logic d, input logic r);
    wr_en = 1'b1; wr_sclk = s; wr_sdi = d; wr_req = r;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic edge_bit(input logic d);
    wr(1'b0, d, 1'b1);
    wr(1'b1, d, 1'b1);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) edge_bit(b[i]);
  endtask

  task automatic read_word(input logic [7:0] a, output logic [15:0] w);
    send_byte(8'h03);
    send_byte(a);
    for (int i = 15; i >= 0; i--) begin
      edge_bit(1'b0);
      w[i] = sdo;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(sdo == 1'b0, "R1 sdo after reset", int'(sdo), 0);
    chk(gnt == 1'b0, "R1 gnt after reset", int'(gnt), 0);
    chk(err == 1'b0, "R1 err after reset", int'(err), 0);
  endtask

  task automatic t_grant();
    wr(1'b0, 1'b0, 1'b1);
    chk(gnt == 1'b1, "R2 gnt follows req=1", int'(gnt), 1);
    repeat (3) @(negedge clk);
    chk(gnt == 1'b1, "R2 gnt holds without write", int'(gnt), 1);
    wr(1'b0, 1'b0, 1'b0);
    chk(gnt == 1'b0, "R2 gnt follows req=0", int'(gnt), 0);
  endtask

  task automatic t_read_map();
    logic [15:0] w;
    read_word(8'h02, w);
    chk(w == 16'hB6B6, "R4 R5 byte addr 0x02 -> word1", int'(w), 'hB6B6);
    read_word(8'h05, w);
    chk(w == 16'hC8C8, "R4 byte addr 0x05 -> word2", int'(w), 'hC8C8);
    read_word(8'h01, w);
    chk(w == 16'hA4A4, "R4 byte addr 0x01 -> word0", int'(w), 'hA4A4);
    chk(err == 1'b0, "R4 no error on legal reads", int'(err), 0);
  endtask

  task automatic t_glitch();
    logic [15:0] w;
    logic hold;
    // command bits with extra non-edge writes carrying inverted data
    for (int i = 7; i >= 0; i--) begin
      edge_bit(8'h03 >> i);
      wr(1'b1, ~(8'h03 >> i), 1'b1);
    end
    for (int i = 7; i >= 0; i--) begin
      edge_bit(8'h7E >> i);
      wr(1'b1, ~(8'h7E >> i), 1'b1);
      wr(1'b0, ~(8'h7E >> i), 1'b1);
    end
    for (int i = 15; i >= 0; i--) begin
      edge_bit(1'b0);
      w[i] = sdo;
      hold = sdo;
      wr(1'b1, 1'b1, 1'b1);
      wr(1'b0, 1'b1, 1'b1);
      if (i == 3) chk(sdo == hold, "R3 sdo held over non-edge writes", int'(sdo), int'(hold));
    end
    chk(w == 16'h9698, "R3 word63 intact despite extra writes", int'(w), 'h9698);
  endtask

  task automatic t_status();
    int zeros = 0;
    send_byte(8'h05);
    for (int i = 0; i < 8; i++) begin
      edge_bit(1'b1);
      if (sdo == 1'b0) zeros++;
    end
    chk(zeros == 8, "R6 status bits all zero", zeros, 8);
  endtask

  task automatic t_back_to_back();
    logic [15:0] w;
    send_byte(8'h05);
    for (int i = 0; i < 8; i++) edge_bit(1'b0);
    read_word(8'h00, w);
    chk(w == 16'hA4A4, "R7 read right after status", int'(w), 'hA4A4);
    read_word(8'h03, w);
    chk(w == 16'hB6B6, "R7 read right after read", int'(w), 'hB6B6);
  endtask

  task automatic t_contents();
    logic [15:0] w;
    logic [15:0] sum = '0;
    int bad = 0;
    for (int k = 0; k < 64; k++) begin
      read_word(8'(2 * k), w);
      sum = sum + w;
      if (k >= 3 && k <= 62 && w != 16'h0) bad++;
      if (k == 63) chk(w == 16'h9698, "R8 word63 checksum", int'(w), 'h9698);
    end
    chk(bad == 0, "R8 words 3..62 zero", bad, 0);
    chk(sum == 16'hBABA, "R8 sum of all words", int'(sum), 'hBABA);
  endtask

  task automatic t_bad_cmd();
    for (int i = 7; i >= 1; i--) edge_bit(8'h02 >> i);
    chk(err == 1'b0, "R9 no error before 8th command bit", int'(err), 0);
    edge_bit(1'b0);
    chk(err == 1'b1, "R9 error after bad command", int'(err), 1);
    edge_bit(1'b1);
    repeat (2) @(negedge clk);
    chk(err == 1'b1, "R9 error sticky", int'(err), 1);
    do_reset();
    chk(err == 1'b0, "R9 reset clears error", int'(err), 0);
  endtask

  task automatic t_oob();
    send_byte(8'h03);
    for (int i = 7; i >= 1; i--) edge_bit(8'h80 >> i);
    chk(err == 1'b0, "R10 no error before 8th address bit", int'(err), 0);
    edge_bit(1'b0);
    chk(err == 1'b1, "R10 error on address 0x80", int'(err), 1);
    do_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_grant();
    t_read_map();
    t_glitch();
    t_status();
    t_back_to_back();
    t_contents();
    t_bad_cmd();
    t_oob();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule